// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block comes out of reset and fills a chip's register space from an image held in a serial EEPROM. It reads the image one byte at a time through a request/response port that carries a 16-bit byte address. It assembles the bytes into fixed-size records and turns each write record into one register write. While it reads, it keeps a running 8-bit checksum. Loading ends when a configuration-done command and its checksum byte have been read, when a malformed command appears, or when the image runs off the end of the address space.

A write record is seven bytes: the command `0x01`, the register address (high byte, then low byte), and a 32-bit data word with the most significant byte first. The done command `0xFF` is followed by a single checksum byte. Before each write, the loader shows the record address on the register port and samples the `cfg_mapped` response. A record whose address is not mapped is skipped and flagged, and loading carries on. There are two sticky error flags, one for the checksum and one for unmapped targets. Each is cleared by a one-cycle clear pulse (write-1-to-clear) or by reset.

Both data paths use valid/ready handshakes. A byte request stays valid with a stable address until `rd_req_ready` is high. At most one request is outstanding at a time. `rd_rsp_ready` is high only while that request waits for its byte, and the responder may delay `rd_rsp_valid` for as long as it needs. A register write holds `cfg_valid`, `cfg_addr` and `cfg_data` steady until `cfg_ready` is high, so the register file can stall the loader for any number of cycles.

Top module: `cfg_loader`

## Requirements
- R1: After reset is released, the loader requests bytes starting at address 0x0000, one request per byte, with each address one higher than the last.
- R2: Each record with command byte 0x01 and a mapped address (address high byte, then low byte, then data MSB first) produces exactly one write with that address and data. Writes appear in image order.
- R3: A record whose address has `cfg_mapped` low when sampled produces no write. It sets `unmapped_err`, and the loader goes on to the next record.
- R4: The checksum is the 8-bit sum of every byte from address 0 up to and including the 0xFF command byte. If the sum plus the checksum byte is not 0 modulo 256, `csum_err` is set.
- R5: While `ignore_csum` is high, the checksum comparison passes.
- R6: Loading stops and sets `csum_err` in either of two cases: a command byte other than 0x01 or 0xFF is read, or a further byte is needed after address 0xFFFF. This happens whatever the value of `ignore_csum`. Records after the bad command produce no write.
- R7: `csum_err` and `unmapped_err` stay set until their own clear pulse or reset. Clearing one flag leaves the other unchanged.
- R8: `done` pulses for exactly one cycle per load, whether or not errors occurred. `busy` is low from that cycle on, and no further request or write is issued.
- R9: A request or write that is not yet accepted stays valid with stable address and data. Only one byte request is outstanding at a time.
- R10: During reset, `busy`, `done`, both error flags, `rd_req_valid` and `cfg_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loading starts after release |
| ignore_csum | input | 1 | Forces the checksum comparison to pass |
| rd_req_valid | output | 1 | Byte request valid |
| rd_req_ready | input | 1 | Byte request accepted |
| rd_req_addr | output | 16 | EEPROM byte address |
| rd_rsp_valid | input | 1 | Byte response valid |
| rd_rsp_ready | output | 1 | Loader waits for a byte |
| rd_rsp_data | input | 8 | Byte read from the EEPROM |
| cfg_valid | output | 1 | Register write valid |
| cfg_ready | input | 1 | Register write accepted |
| cfg_addr | output | 16 | Register address of the current record |
| cfg_data | output | 32 | Register write data |
| cfg_mapped | input | 1 | High when `cfg_addr` names an existing register |
| clr_csum_err | input | 1 | Clear pulse for `csum_err` |
| clr_unmapped_err | input | 1 | Clear pulse for `unmapped_err` |
| csum_err | output | 1 | Sticky checksum / missing-done error |
| unmapped_err | output | 1 | Sticky unmapped-target error |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse when the load ends |

## Verification
A clean image of mapped writes is loaded twice: once with free-flowing handshakes and once with stalls on every interface. Comparing the two separates the record parsing from the back-pressure handling. A copy of the clean image with one bit flipped in the checksum byte is loaded with `ignore_csum` low and then high, which shows the comparison and its override acting separately. An unmapped record placed between mapped ones shows that skipping does not disturb the neighbouring records. A bad command byte, tried with and without the override, and an image with no done command that runs to address 0xFFFF, check the two ways the load can end early.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h01;
  localparam logic [7:0] CMD_DONE  = 8'hFF;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_FETCH,
    ST_LOOKUP,
    ST_WRITE,
    ST_FINISH,
    ST_HALT
  } ld_state_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_BODY,
    PH_CSUM
  } rec_phase_e;

  localparam int unsigned N_FLAGS = 2;
  localparam int unsigned FLAG_CSUM = 0;
  localparam int unsigned FLAG_UNMAPPED = 1;
endpackage

// File: rtl/cl_byte_fetch.sv
module cl_byte_fetch #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  output logic              byte_vld,
  output logic [7:0]        byte_data,
  output logic              exhausted
);
  logic [ADDR_W:0] next_q;
  logic            outst_q;

  assign req_valid = want && !outst_q && !next_q[ADDR_W];
  assign req_addr  = next_q[ADDR_W-1:0];
  assign rsp_ready = outst_q;
  assign byte_vld  = rsp_valid && outst_q;
  assign byte_data = rsp_data;
  assign exhausted = next_q[ADDR_W] && !outst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q  <= '0;
      outst_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        next_q  <= next_q + (ADDR_W+1)'(1);
        outst_q <= 1'b1;
      end else if (byte_vld) begin
        outst_q <= 1'b0;
      end
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> req_addr == $past(req_addr) + ADDR_W'(1));
endmodule

// File: rtl/cl_csum_acc.sv
module cl_csum_acc #(
  parameter int unsigned SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [SUM_W-1:0] add_val,
  input  logic [SUM_W-1:0] chk_val,
  output logic [SUM_W-1:0] sum,
  output logic             sum_ok
);
  logic [SUM_W-1:0] total;

  always_ff @(posedge clk) begin
    if (!rst_n) sum <= '0;
    else if (add_en) sum <= sum + add_val;
  end

  assign total  = sum + chk_val;
  assign sum_ok = (total == '0);

  p_sum_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(sum));
endmodule

// File: rtl/cl_sticky_flag.sv
module cl_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q && !clr |=> q);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_AW = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ignore_csum,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [7:0]        rd_rsp_data,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [REG_AW-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_mapped,
  input  logic              clr_csum_err,
  input  logic              clr_unmapped_err,
  output logic              csum_err,
  output logic              unmapped_err,
  output logic              busy,
  output logic              done
);
  localparam int unsigned BODY_BITS  = REG_AW + DATA_W;
  localparam int unsigned BODY_BYTES = BODY_BITS / 8;
  localparam int unsigned CNT_W      = $clog2(BODY_BYTES + 1);

  ld_state_e        state_q, state_d;
  rec_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BODY_BITS-1:0] body_q, body_d;

  logic       want, byte_vld, exhausted;
  logic [7:0] byte_data;
  logic [7:0] sum;
  logic       sum_ok, add_en;
  logic       set_csum, set_unm;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

  cl_byte_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_req_addr),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (rd_rsp_ready),
    .rsp_data  (rd_rsp_data),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .exhausted (exhausted)
  );

  assign add_en = (state_q == ST_FETCH) && byte_vld && (phase_q != PH_CSUM);

  cl_csum_acc #(.SUM_W(8)) u_csum (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (add_en),
    .add_val (byte_data),
    .chk_val (byte_data),
    .sum     (sum),
    .sum_ok  (sum_ok)
  );

  assign flag_set[FLAG_CSUM]     = set_csum;
  assign flag_set[FLAG_UNMAPPED] = set_unm;
  assign flag_clr[FLAG_CSUM]     = clr_csum_err;
  assign flag_clr[FLAG_UNMAPPED] = clr_unmapped_err;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    cl_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[g]),
      .clr   (flag_clr[g]),
      .q     (flag_q[g])
    );
  end

  assign csum_err     = flag_q[FLAG_CSUM];
  assign unmapped_err = flag_q[FLAG_UNMAPPED];

  assign want      = (state_q == ST_FETCH);
  assign cfg_valid = (state_q == ST_WRITE);
  assign cfg_addr  = body_q[BODY_BITS-1 -: REG_AW];
  assign cfg_data  = body_q[DATA_W-1:0];
  assign busy      = (state_q == ST_FETCH) || (state_q == ST_LOOKUP) || (state_q == ST_WRITE);
  assign done      = (state_q == ST_FINISH);

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    body_d   = body_q;
    set_csum = 1'b0;
    set_unm  = 1'b0;
    unique case (state_q)
      ST_BOOT: state_d = ST_FETCH;
      ST_FETCH: begin
        if (byte_vld) begin
          unique case (phase_q)
            PH_CMD: begin
              if (byte_data == CMD_WRITE) begin
                phase_d = PH_BODY;
                cnt_d   = '0;
              end else if (byte_data == CMD_DONE) begin
                phase_d = PH_CSUM;
              end else begin
                set_csum = 1'b1;
                state_d  = ST_FINISH;
              end
            end
            PH_BODY: begin
              body_d = {body_q[BODY_BITS-9:0], byte_data};
              if (cnt_q == CNT_W'(BODY_BYTES - 1)) begin
                phase_d = PH_CMD;
                state_d = ST_LOOKUP;
              end else begin
                cnt_d = cnt_q + CNT_W'(1);
              end
            end
            default: begin
              set_csum = !(ignore_csum || sum_ok);
              state_d  = ST_FINISH;
            end
          endcase
        end else if (exhausted) begin
          set_csum = 1'b1;
          state_d  = ST_FINISH;
        end
      end
      ST_LOOKUP: begin
        if (cfg_mapped) begin
          state_d = ST_WRITE;
        end else begin
          set_unm = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_WRITE: if (cfg_ready) state_d = ST_FETCH;
      ST_FINISH: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      body_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      body_q  <= body_d;
    end
  end

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_data));
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_req_valid && !cfg_valid);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_req_in_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> busy);
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ignore_csum = 1'b0;
  logic        rd_req_valid, rd_rsp_ready, cfg_valid;
  logic        req_rdy = 1'b0, rsp_v = 1'b0, cfg_rdy = 1'b0;
  logic [15:0] rd_req_addr, cfg_addr;
  logic [7:0]  rsp_d = 8'h00;
  logic [31:0] cfg_data;
  logic        cfg_mapped;
  logic        clr_c = 1'b0, clr_u = 1'b0;
  logic        csum_err, unmapped_err, busy, done;

  assign cfg_mapped = (cfg_addr[15:12] == 4'h1);

  cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ignore_csum(ignore_csum),
    .rd_req_valid(rd_req_valid), .rd_req_ready(req_rdy), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rsp_v), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rsp_d),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_rdy), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cfg_mapped(cfg_mapped), .clr_csum_err(clr_c), .clr_unmapped_err(clr_u),
    .csum_err(csum_err), .unmapped_err(unmapped_err), .busy(busy), .done(done)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0]  img[$];
  logic [15:0] exp_a[$];
  logic [31:0] exp_d[$];
  bit  filler = 1'b0, bp = 1'b0;
  int  cyc = 0, gap = 0, req_cnt = 0, done_cnt = 0;
  bit  pend = 0, fire_req = 0, fire_rsp = 0, seen_done = 0, post_act = 0;
  int  paddr = 0, cap_addr = 0, next_addr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_at(input int a);
    if (a < img.size()) return img[a];
    if (filler) return (a % 7 == 0) ? 8'h01 : 8'h00;
    return 8'hEE;
  endfunction

  // EEPROM model, register-port scoreboard monitor and done counter
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      rsp_v = 0; pend = 0; fire_req = 0; fire_rsp = 0;
      req_cnt = 0; done_cnt = 0; seen_done = 0; post_act = 0; next_addr = 0;
    end else begin
      if (fire_rsp) rsp_v = 0;
      if (fire_req) begin pend = 1; gap = bp ? 2 : 0; paddr = cap_addr; end
      if (pend) begin
        if (gap == 0) begin rsp_v = 1; rsp_d = byte_at(paddr); pend = 0; end
        else gap--;
      end
      req_rdy = bp ? cyc[0] : 1'b1;
      fire_req = rd_req_valid && req_rdy;
      if (fire_req) begin
        if (rd_req_addr != next_addr[15:0])
          chk(0, "R1 request address", rd_req_addr, next_addr[15:0]);
        next_addr++; req_cnt++; cap_addr = rd_req_addr;
        if (seen_done) post_act = 1;
      end
      fire_rsp = rsp_v && rd_rsp_ready;
      cfg_rdy = bp ? (cyc % 3 == 2) : 1'b1;
      if (cfg_valid && cfg_rdy) begin
        if (seen_done) post_act = 1;
        if (exp_a.size() == 0) chk(0, "R2 unexpected write", cfg_addr, 0);
        else begin
          logic [15:0] ea; logic [31:0] ed;
          ea = exp_a.pop_front(); ed = exp_d.pop_front();
          chk(cfg_addr == ea, "R2 write address", cfg_addr, ea);
          chk(cfg_data == ed, "R2 write data", cfg_data, ed);
        end
      end
      if (done) begin
        done_cnt++; seen_done = 1;
        chk(!busy, "R8 busy low with done", busy, 0);
      end
    end
  end

  task automatic new_image();
    img.delete(); exp_a.delete(); exp_d.delete(); filler = 0;
  endtask

  task automatic add_rec(input logic [15:0] a, input logic [31:0] d);
    img.push_back(8'h01); img.push_back(a[15:8]); img.push_back(a[7:0]);
    img.push_back(d[31:24]); img.push_back(d[23:16]); img.push_back(d[15:8]); img.push_back(d[7:0]);
    if (a[15:12] == 4'h1) begin exp_a.push_back(a); exp_d.push_back(d); end
  endtask

  task automatic add_done(input bit corrupt);
    logic [7:0] s, c;
    img.push_back(8'hFF);
    s = 8'h00;
    foreach (img[i]) s = s + img[i];
    c = 8'h00 - s;
    if (corrupt) c = c ^ 8'h01;
    img.push_back(c);
  endtask

  task automatic run_load(input bit bpm, input bit ign, input bit chk_reset);
    @(negedge clk);
    rst_n = 0; bp = bpm; ignore_csum = ign;
    repeat (3) @(negedge clk);
    if (chk_reset) begin
      chk(!busy, "R10 busy in reset", busy, 0);
      chk(!done, "R10 done in reset", done, 0);
      chk(!csum_err && !unmapped_err, "R10 flags in reset", {csum_err, unmapped_err}, 0);
      chk(!rd_req_valid, "R10 request in reset", rd_req_valid, 0);
      chk(!cfg_valid, "R10 write in reset", cfg_valid, 0);
    end
    rst_n = 1;
    while (!seen_done) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic end_checks(input string name, input bit ec, input bit eu);
    chk(done_cnt == 1, {"R8 done pulse count ", name}, done_cnt, 1);
    chk(!post_act, {"R8 activity after done ", name}, post_act, 0);
    chk(!busy, {"R8 busy after done ", name}, busy, 0);
    chk(exp_a.size() == 0, {"R2 writes missing ", name}, exp_a.size(), 0);
    chk(csum_err == ec, {"R4 csum_err ", name}, csum_err, ec);
    chk(unmapped_err == eu, {"R3 unmapped_err ", name}, unmapped_err, eu);
  endtask

  task automatic clean_image();
    new_image();
    add_rec(16'h1000, 32'hDEADBEEF);
    add_rec(16'h1A04, 32'h01234567);
    add_rec(16'h1FFC, 32'hFF00A55A);
    add_done(0);
  endtask

  initial begin
    // R1 R2 R10: clean image, free-flowing
    clean_image();
    run_load(0, 0, 1);
    chk(req_cnt == 23, "R1 bytes read clean", req_cnt, 23);
    end_checks("clean", 0, 0);

    // R9 R2: same image under stalls on every port
    clean_image();
    run_load(1, 0, 0);
    end_checks("stalled", 0, 0);

    // R4: corrupted checksum; writes still applied
    new_image(); add_rec(16'h1100, 32'h11223344); add_done(1);
    run_load(0, 0, 0);
    end_checks("bad csum", 1, 0);
    // R7: clear unmapped leaves csum set, then clear csum
    @(negedge clk); clr_u = 1; @(negedge clk); clr_u = 0;
    chk(csum_err, "R7 csum kept after other clear", csum_err, 1);
    repeat (3) @(negedge clk);
    chk(csum_err, "R7 csum sticky", csum_err, 1);
    clr_c = 1; @(negedge clk); clr_c = 0;
    chk(!csum_err, "R7 csum cleared", csum_err, 0);

    // R5: same corrupted image with override
    new_image(); add_rec(16'h1100, 32'h11223344); add_done(1);
    run_load(0, 1, 0);
    end_checks("override", 0, 0);

    // R3: unmapped record between mapped ones
    new_image();
    add_rec(16'h1008, 32'hCAFEF00D);
    add_rec(16'h2008, 32'hBAD0BAD0);
    add_rec(16'h100C, 32'h0BADC0DE);
    add_done(0);
    run_load(1, 0, 0);
    end_checks("unmapped", 0, 1);
    @(negedge clk); clr_c = 1; @(negedge clk); clr_c = 0;
    chk(unmapped_err, "R7 unmapped kept after other clear", unmapped_err, 1);
    clr_u = 1; @(negedge clk); clr_u = 0;
    chk(!unmapped_err, "R7 unmapped cleared", unmapped_err, 0);

    // R6: bad command byte stops the load, with and without override
    for (int k = 0; k < 2; k++) begin
      new_image();
      add_rec(16'h1200, 32'h5555AAAA);
      img.push_back(8'h5A);
      add_rec(16'h1204, 32'h77777777);
      exp_a.pop_back(); exp_d.pop_back();
      add_done(0);
      run_load(0, k[0], 0);
      chk(req_cnt == 8, "R6 reads stop at bad command", req_cnt, 8);
      end_checks(k == 0 ? "R6 bad cmd" : "R6 bad cmd override", 1, 0);
    end

    // R6: no done command, image runs to 0xFFFF
    new_image(); filler = 1;
    run_load(0, 1, 0);
    chk(req_cnt == 65536, "R6 reads up to last address", req_cnt, 65536);
    end_checks("R6 wrap", 1, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R8 watchdog expired actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule